// File: doc/BRIEF.md
# PCI Target Address-Phase Decoder

This block sits on the target side of a two-function PCI device. It watches the multiplexed address/data lines and the command/byte-enable lines. On the first clock of each transaction it decides whether the transaction is for this device. If it is, it decides which function is addressed, which space is targeted and which register or RAM byte is meant. It handles three kinds of access:

- configuration cycles, qualified by the chip-select line;
- I/O accesses to a 256-byte window per function;
- memory accesses to a 256-byte register window or to a 4 KB on-chip RAM window per function.

The base addresses and the space-enable bits of each function come in as inputs and are written elsewhere. The decode result is registered at the address phase. It is held for the data-phase logic until the bus goes idle. Function A is index 0 and function B is index 1. Packed base inputs carry function A in their lowest slice.

Top module: `pci_addr_decoder`

## Requirements
- R1: A configuration command (`cbe_i` = 1010 read, 1011 write) decodes as a hit only if `idsel_i` is high in the address phase. Without it, `hit_o` is 0.
- R2: On a configuration hit, `ad_i[10:8]` selects the function. 000 gives `func_o`=0 and 001 gives `func_o`=1. Any other value gives no hit. `space_o` is 0 and `offset_o` is `ad_i[7:0]`, zero-extended.
- R3: An I/O command (0010 read, 0011 write) hits function f when `ad_i[31:8]` equals that function's I/O base. The hit gives `space_o`=1 and `offset_o`=`ad_i[7:0]`.
- R4: A memory command (0110 read, 0111 write) hits the register window of function f when `ad_i[31:8]` equals its register base. The hit gives `space_o`=2 and `offset_o`=`ad_i[7:0]`.
- R5: A memory command hits the RAM window of function f when `ad_i[31:12]` equals its RAM base. The hit gives `space_o`=3 and `offset_o`=`ad_i[11:0]`.
- R6: I/O windows of function f are ignored while `io_en_i[f]` is 0. Register and RAM windows of f are ignored while `mem_en_i[f]` is 0. Configuration decode ignores both bits.
- R7: When several windows match, every register window beats every RAM window. Among windows of the same kind, the lower function index wins. Exactly one result is reported.
- R8: Any command other than the six listed above gives no hit.
- R9: `write_o` equals bit 0 of `cbe_i` at the address phase. Command and byte-enable changes during the data phase have no effect on any output.
- R10: The address phase is a clock edge with `frame_ni` low whose previous edge sampled `frame_ni` and `irdy_ni` both high. Outputs change one edge later. They then hold, even if `frame_ni` stays low across later edges.
- R11: On an edge that samples both `frame_ni` and `irdy_ni` high, `hit_o` goes to 0 and the other outputs hold. When the address phase misses, all outputs go to 0.
- R12: After reset, all outputs are 0 and the bus is treated as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Transaction framing, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration chip select |
| ad_i | input | 32 | Multiplexed address/data |
| cbe_i | input | 4 | Command / byte enables |
| io_en_i | input | NUM_FUNC | Per-function I/O space enable |
| mem_en_i | input | NUM_FUNC | Per-function memory space enable |
| io_base_i | input | 24*NUM_FUNC | Per-function I/O base, address bits 31:8 |
| reg_base_i | input | 24*NUM_FUNC | Per-function register-window base, bits 31:8 |
| ram_base_i | input | 20*NUM_FUNC | Per-function RAM base, bits 31:12 |
| hit_o | output | 1 | Transaction claimed |
| func_o | output | 1 | Function index |
| space_o | output | 2 | 0 config, 1 I/O, 2 register, 3 RAM |
| write_o | output | 1 | Write direction |
| offset_o | output | 12 | Register or RAM byte offset |

## Verification
A corrupted idle tracker would show up one edge after the bus state changes. Either a back-to-back address would be re-decoded mid-transaction, or a real address phase would be missed, and both change `hit_o` or the held fields on the very next edge. A priority or enable fault shows up as the wrong function or space in the result registered right after the address phase. The bench reaches this with overlapping base windows and toggled enables. Holding checks one and two edges later expose any output that follows the data-phase lines.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;
  localparam logic [1:0] SP_CFG = 2'd0;
  localparam logic [1:0] SP_IO  = 2'd1;
  localparam logic [1:0] SP_REG = 2'd2;
  localparam logic [1:0] SP_RAM = 2'd3;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
endpackage

// File: rtl/pci_cmd_decode.sv
module pci_cmd_decode
  import pci_dec_pkg::*;
(
  input  logic [3:0] cmd_i,
  output logic       is_cfg_o,
  output logic       is_io_o,
  output logic       is_mem_o,
  output logic       is_wr_o
);
  always_comb begin
    is_cfg_o = 1'b0;
    is_io_o  = 1'b0;
    is_mem_o = 1'b0;
    unique case (cmd_i)
      CMD_IO_RD,  CMD_IO_WR:  is_io_o  = 1'b1;
      CMD_MEM_RD, CMD_MEM_WR: is_mem_o = 1'b1;
      CMD_CFG_RD, CMD_CFG_WR: is_cfg_o = 1'b1;
      default: ;
    endcase
    is_wr_o = cmd_i[0];
  end
endmodule

// File: rtl/pci_func_window.sv
module pci_func_window #(
  parameter int AW         = 32,
  parameter int REG_BASE_W = 24,
  parameter int RAM_BASE_W = 20
) (
  input  logic [AW-1:0]         addr_i,
  input  logic                  is_io_i,
  input  logic                  is_mem_i,
  input  logic                  io_en_i,
  input  logic                  mem_en_i,
  input  logic [REG_BASE_W-1:0] io_base_i,
  input  logic [REG_BASE_W-1:0] reg_base_i,
  input  logic [RAM_BASE_W-1:0] ram_base_i,
  output logic                  io_hit_o,
  output logic                  reg_hit_o,
  output logic                  ram_hit_o
);
  logic [REG_BASE_W-1:0] upper_reg;
  logic [RAM_BASE_W-1:0] upper_ram;

  assign upper_reg = addr_i[AW-1 -: REG_BASE_W];
  assign upper_ram = addr_i[AW-1 -: RAM_BASE_W];

  assign io_hit_o  = is_io_i  && io_en_i  && (upper_reg == io_base_i);
  assign reg_hit_o = is_mem_i && mem_en_i && (upper_reg == reg_base_i);
  assign ram_hit_o = is_mem_i && mem_en_i && (upper_ram == ram_base_i);
endmodule

// File: rtl/pci_hit_select.sv
module pci_hit_select
  import pci_dec_pkg::*;
#(
  parameter int NF = 2,
  parameter int FW = 1
) (
  input  logic          is_cfg_i,
  input  logic          is_io_i,
  input  logic          is_mem_i,
  input  logic          cfg_ok_i,
  input  logic [FW-1:0] cfg_func_i,
  input  logic [NF-1:0] io_hit_i,
  input  logic [NF-1:0] reg_hit_i,
  input  logic [NF-1:0] ram_hit_i,
  output logic          hit_o,
  output logic [FW-1:0] func_o,
  output logic [1:0]    space_o
);
  always_comb begin
    hit_o   = 1'b0;
    func_o  = '0;
    space_o = SP_CFG;
    if (is_cfg_i) begin
      hit_o  = cfg_ok_i;
      func_o = cfg_func_i;
    end else if (is_io_i) begin
      // descending scan: lowest index assigned last, wins
      for (int f = NF - 1; f >= 0; f--) begin
        if (io_hit_i[f]) begin
          hit_o   = 1'b1;
          func_o  = FW'(f);
          space_o = SP_IO;
        end
      end
    end else if (is_mem_i) begin
      for (int f = NF - 1; f >= 0; f--) begin
        if (ram_hit_i[f]) begin
          hit_o   = 1'b1;
          func_o  = FW'(f);
          space_o = SP_RAM;
        end
      end
      // register windows override any RAM match
      for (int f = NF - 1; f >= 0; f--) begin
        if (reg_hit_i[f]) begin
          hit_o   = 1'b1;
          func_o  = FW'(f);
          space_o = SP_REG;
        end
      end
    end
  end
endmodule

// File: rtl/pci_addr_decoder.sv
module pci_addr_decoder
  import pci_dec_pkg::*;
#(
  parameter  int NUM_FUNC   = 2,
  parameter  int REG_BASE_W = 24,
  parameter  int RAM_BASE_W = 20,
  localparam int AW         = 32,
  localparam int FUNC_W     = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1,
  localparam int REG_OFF_W  = AW - REG_BASE_W,
  localparam int OFF_W      = AW - RAM_BASE_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           frame_ni,
  input  logic                           irdy_ni,
  input  logic                           idsel_i,
  input  logic [AW-1:0]                  ad_i,
  input  logic [3:0]                     cbe_i,
  input  logic [NUM_FUNC-1:0]            io_en_i,
  input  logic [NUM_FUNC-1:0]            mem_en_i,
  input  logic [NUM_FUNC*REG_BASE_W-1:0] io_base_i,
  input  logic [NUM_FUNC*REG_BASE_W-1:0] reg_base_i,
  input  logic [NUM_FUNC*RAM_BASE_W-1:0] ram_base_i,
  output logic                           hit_o,
  output logic [FUNC_W-1:0]              func_o,
  output logic [1:0]                     space_o,
  output logic                           write_o,
  output logic [OFF_W-1:0]               offset_o
);
  logic is_cfg, is_io, is_mem, is_wr;
  logic cfg_ok;
  logic [FUNC_W-1:0] cfg_func;
  logic [NUM_FUNC-1:0] io_hit, reg_hit, ram_hit;
  logic hit_d;
  logic [FUNC_W-1:0] func_d;
  logic [1:0] space_d;
  logic [OFF_W-1:0] off_d;
  logic idle_q, start, bus_idle;

  pci_cmd_decode u_cmd (
    .cmd_i   (cbe_i),
    .is_cfg_o(is_cfg),
    .is_io_o (is_io),
    .is_mem_o(is_mem),
    .is_wr_o (is_wr)
  );

  assign cfg_ok   = idsel_i && (int'(ad_i[10:8]) < NUM_FUNC);
  assign cfg_func = FUNC_W'(ad_i[10:8]);

  for (genvar g = 0; g < NUM_FUNC; g++) begin : g_fn
    pci_func_window #(
      .AW        (AW),
      .REG_BASE_W(REG_BASE_W),
      .RAM_BASE_W(RAM_BASE_W)
    ) u_win (
      .addr_i    (ad_i),
      .is_io_i   (is_io),
      .is_mem_i  (is_mem),
      .io_en_i   (io_en_i[g]),
      .mem_en_i  (mem_en_i[g]),
      .io_base_i (io_base_i[g*REG_BASE_W +: REG_BASE_W]),
      .reg_base_i(reg_base_i[g*REG_BASE_W +: REG_BASE_W]),
      .ram_base_i(ram_base_i[g*RAM_BASE_W +: RAM_BASE_W]),
      .io_hit_o  (io_hit[g]),
      .reg_hit_o (reg_hit[g]),
      .ram_hit_o (ram_hit[g])
    );
  end

  pci_hit_select #(
    .NF(NUM_FUNC),
    .FW(FUNC_W)
  ) u_sel (
    .is_cfg_i  (is_cfg),
    .is_io_i   (is_io),
    .is_mem_i  (is_mem),
    .cfg_ok_i  (cfg_ok),
    .cfg_func_i(cfg_func),
    .io_hit_i  (io_hit),
    .reg_hit_i (reg_hit),
    .ram_hit_i (ram_hit),
    .hit_o     (hit_d),
    .func_o    (func_d),
    .space_o   (space_d)
  );

  assign off_d = (space_d == SP_RAM) ? ad_i[OFF_W-1:0]
                                     : {{(OFF_W-REG_OFF_W){1'b0}}, ad_i[REG_OFF_W-1:0]};

  assign bus_idle = frame_ni && irdy_ni;
  assign start    = !frame_ni && idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q   <= 1'b1;
      hit_o    <= 1'b0;
      func_o   <= '0;
      space_o  <= SP_CFG;
      write_o  <= 1'b0;
      offset_o <= '0;
    end else begin
      idle_q <= bus_idle;
      if (start) begin
        hit_o    <= hit_d;
        func_o   <= hit_d ? func_d  : '0;
        space_o  <= hit_d ? space_d : SP_CFG;
        write_o  <= hit_d && is_wr;
        offset_o <= hit_d ? off_d   : '0;
      end else if (bus_idle) begin
        hit_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pci_addr_decoder_chk.sv
module pci_addr_decoder_chk #(
  parameter int NUM_FUNC = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        frame_ni,
  input logic        irdy_ni,
  input logic        idsel_i,
  input logic [10:0] ad_lo_i,
  input logic [3:0]  cbe_i,
  input logic        hit_o,
  input logic [1:0]  space_o,
  input logic        write_o,
  input logic [11:0] offset_o
);
  logic was_idle;
  logic begin_txn, idle_now, cfg_cmd, io_cmd, known_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) was_idle <= 1'b1;
    else         was_idle <= frame_ni & irdy_ni;
  end

  assign begin_txn = !frame_ni && was_idle;
  assign idle_now  = frame_ni && irdy_ni;
  assign cfg_cmd   = cbe_i[3:1] == 3'b101;
  assign io_cmd    = cbe_i[3:1] == 3'b001;
  assign known_cmd = cfg_cmd || io_cmd || (cbe_i[3:1] == 3'b011);

  AST_CFG_NEEDS_IDSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    begin_txn && cfg_cmd && !idsel_i |=> !hit_o); // R1

  AST_CFG_FUNC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    begin_txn && cfg_cmd && (int'(ad_lo_i[10:8]) >= NUM_FUNC) |=> !hit_o); // R2

  AST_IO_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    begin_txn && io_cmd |=> !hit_o || (space_o == 2'd1 && offset_o == {4'h0, $past(ad_lo_i[7:0])})); // R3

  AST_UNKNOWN_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    begin_txn && !known_cmd |=> !hit_o); // R8

  AST_DIR_FROM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    begin_txn && known_cmd |=> !hit_o || (write_o == $past(cbe_i[0]))); // R9

  AST_HOLD_IN_TXN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !begin_txn && !idle_now |=> $stable({hit_o, space_o, write_o, offset_o})); // R10

  AST_IDLE_DROPS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_now |=> !hit_o); // R11
endmodule

bind pci_addr_decoder pci_addr_decoder_chk #(.NUM_FUNC(NUM_FUNC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .frame_ni(frame_ni),
  .irdy_ni (irdy_ni),
  .idsel_i (idsel_i),
  .ad_lo_i (ad_i[10:0]),
  .cbe_i   (cbe_i),
  .hit_o   (hit_o),
  .space_o (space_o),
  .write_o (write_o),
  .offset_o(offset_o)
);

// File: tb/sim_pci_addr_decoder.sv
module sim_pci_addr_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0] cbe = '0;
  logic [1:0] io_en = 2'b11, mem_en = 2'b11;
  logic [23:0] bio [2];
  logic [23:0] bmem [2];
  logic [19:0] bram [2];
  logic hit, func, wr;
  logic [1:0] space;
  logic [11:0] off;
  int checks = 0, errors = 0;
  logic [3:0] cmds [6] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB};

  always #4 clk = ~clk;

  pci_addr_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .idsel_i(idsel), .ad_i(ad), .cbe_i(cbe), .io_en_i(io_en), .mem_en_i(mem_en),
    .io_base_i({bio[1], bio[0]}), .reg_base_i({bmem[1], bmem[0]}),
    .ram_base_i({bram[1], bram[0]}),
    .hit_o(hit), .func_o(func), .space_o(space), .write_o(wr), .offset_o(off)
  );

  function automatic logic [16:0] exp_dec(logic [3:0] c, logic [31:0] a, logic id);
    if (c == 4'hA || c == 4'hB) begin
      if (id && a[10:8] < 3'd2) return {1'b1, a[8], 2'd0, c[0], 4'h0, a[7:0]};
      return '0;
    end
    if (c == 4'h2 || c == 4'h3) begin
      for (int f = 0; f < 2; f++)
        if (io_en[f] && a[31:8] == bio[f]) return {1'b1, f[0], 2'd1, c[0], 4'h0, a[7:0]};
      return '0;
    end
    if (c == 4'h6 || c == 4'h7) begin
      for (int f = 0; f < 2; f++)
        if (mem_en[f] && a[31:8] == bmem[f]) return {1'b1, f[0], 2'd2, c[0], 4'h0, a[7:0]};
      for (int f = 0; f < 2; f++)
        if (mem_en[f] && a[31:12] == bram[f]) return {1'b1, f[0], 2'd3, c[0], a[11:0]};
    end
    return '0;
  endfunction

  task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] outs();
    return {hit, func, space, wr, off};
  endfunction

  // address phase, one data phase, then idle
  task automatic txn(logic [3:0] c, logic [31:0] a, logic id, string tag);
    logic [16:0] e;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe = c; idsel = id;
    e = exp_dec(c, a, id);
    @(negedge clk);
    check(tag, outs(), e);
    frame_n = 1'b1; irdy_n = 1'b0; ad = $urandom; cbe = 4'($urandom); idsel = $urandom;
    @(negedge clk);
    check({tag, " R9 R10 hold"}, outs(), e);
    irdy_n = 1'b1; idsel = 1'b0;
    @(negedge clk);
    check({tag, " R11 idle"}, outs(), {1'b0, e[15:0]});
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    bio[0] = 24'h00C0A1;  bio[1] = 24'h00C0B2;
    bmem[0] = 24'hFE1000; bmem[1] = 24'hFE2000;
    bram[0] = 20'hFD000;  bram[1] = 20'hFD001;
    repeat (3) @(negedge clk);
    check("R12 reset", outs(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after reset", outs(), '0);

    txn(4'hA, 32'h0000_0010, 1'b1, "R2 cfg A");
    txn(4'hB, 32'h0000_01FC, 1'b1, "R2 cfg B write");
    txn(4'hA, 32'h0000_0210, 1'b1, "R2 cfg bad func");
    txn(4'hB, 32'h0000_0104, 1'b0, "R1 cfg no idsel");
    txn(4'h3, 32'h00C0_B27E, 1'b0, "R3 io B");
    txn(4'h6, 32'hFE10_0033, 1'b0, "R4 reg A");
    txn(4'h7, 32'hFD00_1ABC, 1'b0, "R5 ram B");
    txn(4'hE, 32'hFE10_0033, 1'b1, "R8 unknown cmd");
    io_en = 2'b10;
    txn(4'h2, 32'h00C0_A100, 1'b0, "R6 io disabled");
    mem_en = 2'b00;
    txn(4'h6, 32'hFD00_0004, 1'b0, "R6 mem disabled");
    txn(4'hA, 32'h0000_0120, 1'b1, "R6 cfg ignores enables");
    io_en = 2'b11; mem_en = 2'b11;
    bmem[1] = 24'hFD0003;
    txn(4'h6, 32'hFD00_0344, 1'b0, "R7 reg over ram");
    bio[1] = bio[0];
    txn(4'h3, 32'h00C0_A155, 1'b0, "R7 func A first");
    bio[1] = 24'h00C0B2; bmem[1] = 24'hFE2000;

    // R10: frame held low, later edges are not address phases
    @(negedge clk);
    frame_n = 1'b0; ad = 32'hFE20_0011; cbe = 4'h7;
    @(negedge clk);
    check("R10 start", outs(), {1'b1, 1'b1, 2'd2, 1'b1, 12'h011});
    ad = 32'h0000_0000; cbe = 4'hA; idsel = 1'b1;
    @(negedge clk);
    check("R10 no redecode", outs(), {1'b1, 1'b1, 2'd2, 1'b1, 12'h011});
    frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0;
    @(negedge clk);
    check("R11 idle after burst", outs(), {1'b0, 1'b1, 2'd2, 1'b1, 12'h011});

    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      logic [31:0] a;
      int f, k;
      f = int'($urandom % 2);
      k = int'($urandom % 5);
      c = ($urandom % 8 == 0) ? 4'($urandom) : cmds[$urandom % 6];
      a = $urandom;
      case (k)
        0: a[31:8]  = bio[f];
        1: a[31:8]  = bmem[f];
        2: a[31:12] = bram[f];
        3: a[10:8]  = 3'($urandom % 3);
        default: ;
      endcase
      io_en  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      mem_en = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      txn(c, a, 1'($urandom), "R1-mix random");
    end
    finish_run();
  end
endmodule